// File: doc/BRIEF.md
# Dual-channel IDE function configuration registers

This block is the configuration register file of a two-channel IDE function on a PCI bus. It accepts single-cycle 32-bit configuration reads and writes addressed by byte offset and qualified by byte enables. It holds the identification and class words, a programming-interface byte, five base address registers, the interrupt routing bytes, a vendor control window and an interrupt status flag. It hands the decode base of each channel's command and control blocks and of the bus-master block to the surrounding address decoders.

Each channel has a mode bit in the programming-interface byte. In legacy mode the channel decodes at fixed addresses. In native mode it decodes at whatever software programmed into its base registers. Every programmed base value is kept in a shadow register. When a mode bit flips, the live decode bases of that channel are reloaded from the shadow or from the fixed table. Software can therefore program native addresses while a channel still runs in legacy mode and switch over later. Two dword pairs near the top of configuration space are passed through to an external bus-master register file.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset the decode bases are 0x1F0 (primary command), 0x3F4 (primary control), 0x170 (secondary command), 0x374 (secondary control) and 0xF00 (bus-master). The interrupt line byte reads 0x0E and the interrupt pin byte reads 0x01.
- R2: Bit 0 of the programming-interface byte (byte 1 of the dword at 0x08) selects native mode (1) or legacy mode (0) for the primary channel. In legacy mode the primary bases are 0x1F0 and 0x3F4.
- R3: Bit 2 of the programming-interface byte selects the mode of the secondary channel in the same way. In legacy mode the secondary bases are 0x170 and 0x374.
- R4: A write to a base register (dwords 0x10, 0x14, 0x18, 0x1C, 0x20) is always saved in its shadow. It reaches the live command or control base on the next cycle only if that channel is in native mode. The bus-master base at 0x20 is always live.
- R5: A base register write of 0xFFFFFFFF with all four byte enables set is a size probe. It changes neither the shadow nor the live bases.
- R6: A programming-interface write that flips a channel's mode bit reloads that channel's live bases on the next cycle: from the shadows when entering native mode, and from the fixed addresses when entering legacy mode.
- R7: The bus-master decode enable output is high exactly while the primary channel is in native mode.
- R8: In the dword at 0x08 only byte 1 is writable. It reads back as {class 0x01, subclass 0x01, programming interface, revision}.
- R9: The interrupt line (0x3C) and pin (0x3D) bytes are each written under their own byte enable.
- R10: The eight dwords 0x40 to 0x5C store writes under byte enables and read back what was stored. The exception is bit 2 of 0x50, which reads as the interrupt status.
- R11: A rising edge on the primary interrupt request sets the status bit (0x50 bit 2), and the interrupt output follows it on the next cycle. A write with byte 0 enabled and data bit 2 set clears it. A set in the same cycle as a clear wins.
- R12: An access to 0x70 to 0x77 selects the primary bus-master registers (select 01), and an access to 0x78 to 0x7F selects the secondary ones (select 10). Byte offset bit 2 is passed through as the register index. Reads in that range return the external read data.
- R13: A base register write with only some byte enables set replaces only those bytes of the shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 32 | Write data |
| cfgByteEn | input | 4 | Byte enables for writes |
| cfgRdData | output | 32 | Read data, combinational from cfgAddr |
| priIrqReq | input | 1 | Primary channel interrupt request |
| intOut | output | 1 | Interrupt status output |
| priCmdBase | output | 32 | Primary command block decode base |
| priCtlBase | output | 32 | Primary control block decode base |
| secCmdBase | output | 32 | Secondary command block decode base |
| secCtlBase | output | 32 | Secondary control block decode base |
| bmBase | output | 32 | Bus-master block decode base |
| bmEnable | output | 1 | Bus-master decode enable |
| chNative | output | 2 | Native-mode flags, bit 0 primary, bit 1 secondary |
| bmCfgSel | output | 2 | Bus-master register alias select, 01 primary, 10 secondary |
| bmCfgOff | output | 1 | Dword index within the aliased pair |
| bmCfgWr | output | 1 | Write strobe to the aliased registers |
| bmCfgRd | output | 1 | Read strobe to the aliased registers |
| bmCfgRdData | input | 32 | Read data from the aliased registers |

## Verification
The checker watches, on every cycle, that a channel in legacy mode shows its fixed bases, that a size probe leaves every base untouched, that the status bit follows request edges and clears, and that the alias select is decoded and never has both bits set. The bench has to show the rest through sequences. Shadow values survive legacy periods and reappear after a mode switch. Partial writes merge by byte. The class bytes resist writes. The vendor window stores and reads back across byte-enable patterns. A set wins over a clear that arrives in the same cycle.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

  localparam int NUM_BARS    = 5;
  localparam int NUM_CH_BARS = 4;
  localparam int VEND_WORDS  = 8;
  localparam int VEND_IDX_W  = $clog2(VEND_WORDS);
  localparam int BAR_IDX_W   = $clog2(NUM_BARS);
  localparam int STAT_WORD   = 4;
  localparam int STAT_BIT    = 2;

  // dword indices inside configuration space
  localparam logic [5:0] DW_ID     = 6'd0;
  localparam logic [5:0] DW_CLASS  = 6'd2;
  localparam logic [5:0] DW_BAR0   = 6'd4;
  localparam logic [5:0] DW_INTR   = 6'd15;
  localparam logic [5:0] DW_VEND0  = 6'd16;

  typedef enum logic [2:0] {
    RD_ZERO, RD_ID, RD_CLASS, RD_BAR, RD_INTR, RD_VEND, RD_BM
  } rdSel_e;

  typedef struct packed {
    logic                   progIfWr;
    logic [NUM_BARS-1:0]    barWr;
    logic                   barProbe;
    logic                   intrWr;
    logic                   vendWr;
    logic [VEND_IDX_W-1:0]  vendIdx;
    logic [BAR_IDX_W-1:0]   barIdx;
    rdSel_e                 rdSel;
  } cfgStrobe_t;

  // fixed legacy bases for BAR0..3, bus-master default for BAR4
  function automatic logic [31:0] fixedBase(input int idx);
    case (idx)
      0:       return 32'h0000_01F0;
      1:       return 32'h0000_03F4;
      2:       return 32'h0000_0170;
      3:       return 32'h0000_0374;
      default: return 32'h0000_0F00;
    endcase
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++)
      res[b*8 +: 8] = be[b] ? newVal[b*8 +: 8] : oldVal[b*8 +: 8];
    return res;
  endfunction

endpackage

// File: rtl/ide_cfg_ctrl.sv
module ide_cfg_ctrl
  import ide_cfg_pkg::*;
(
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic [3:0]  cfgByteEn,
  output cfgStrobe_t  strobe,
  output logic [1:0]  bmCfgSel,
  output logic        bmCfgOff,
  output logic        bmCfgWr,
  output logic        bmCfgRd
);

  logic [5:0] dwIdx;
  logic [5:0] barRel;
  logic       barHit;
  logic       vendHit;
  logic       bmHit;

  assign dwIdx   = cfgAddr[7:2];
  assign barRel  = dwIdx - DW_BAR0;
  assign barHit  = (dwIdx >= DW_BAR0) && (barRel < 6'(NUM_BARS));
  assign vendHit = (dwIdx >= DW_VEND0) && (dwIdx < DW_VEND0 + 6'(VEND_WORDS));
  assign bmHit   = (dwIdx[5:2] == 4'b0111);

  always_comb begin
    strobe          = '0;
    strobe.barIdx   = barRel[BAR_IDX_W-1:0];
    strobe.vendIdx  = dwIdx[VEND_IDX_W-1:0];
    strobe.progIfWr = cfgWrEn && (dwIdx == DW_CLASS) && cfgByteEn[1];
    strobe.intrWr   = cfgWrEn && (dwIdx == DW_INTR);
    strobe.vendWr   = cfgWrEn && vendHit;
    strobe.barProbe = (cfgByteEn == 4'hF) && (cfgWrData == 32'hFFFF_FFFF);
    if (cfgWrEn && barHit)
      strobe.barWr[strobe.barIdx] = 1'b1;

    if (dwIdx == DW_ID)         strobe.rdSel = RD_ID;
    else if (dwIdx == DW_CLASS) strobe.rdSel = RD_CLASS;
    else if (barHit)            strobe.rdSel = RD_BAR;
    else if (dwIdx == DW_INTR)  strobe.rdSel = RD_INTR;
    else if (vendHit)           strobe.rdSel = RD_VEND;
    else if (bmHit)             strobe.rdSel = RD_BM;
    else                        strobe.rdSel = RD_ZERO;
  end

  always_comb begin
    bmCfgSel = 2'b00;
    if (bmHit && (cfgWrEn || cfgRdEn))
      bmCfgSel = dwIdx[1] ? 2'b10 : 2'b01;
  end

  assign bmCfgOff = dwIdx[0];
  assign bmCfgWr  = cfgWrEn && bmHit;
  assign bmCfgRd  = cfgRdEn && bmHit;

endmodule

// File: rtl/ide_cfg_dp.sv
module ide_cfg_dp
  import ide_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1AB3,
  parameter logic [15:0] DEVICE_ID     = 16'h0C46,
  parameter logic [7:0]  REVISION      = 8'h07,
  parameter logic [15:0] CLASS_CODE    = 16'h0101,
  parameter logic [7:0]  PROG_IF_INIT  = 8'h80,
  parameter logic [7:0]  INT_LINE_INIT = 8'h0E,
  parameter logic [7:0]  INT_PIN_INIT  = 8'h01
)(
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  input  logic [31:0] cfgWrData,
  input  logic [3:0]  cfgByteEn,
  input  logic        priIrqReq,
  input  logic [31:0] bmCfgRdData,
  output logic [31:0] cfgRdData,
  output logic [31:0] priCmdBase,
  output logic [31:0] priCtlBase,
  output logic [31:0] secCmdBase,
  output logic [31:0] secCtlBase,
  output logic [31:0] bmBase,
  output logic        bmEnable,
  output logic [1:0]  chNative,
  output logic        intOut
);

  localparam logic [31:0] STAT_MASK = 32'(1) << STAT_BIT;

  logic [7:0]  progIf;
  logic [7:0]  intLine;
  logic [7:0]  intPin;
  logic [31:0] shadowBar [NUM_BARS];
  logic [31:0] liveBar   [NUM_CH_BARS];
  logic [31:0] vendWord  [VEND_WORDS];
  logic        statBit;
  logic        irqPrev;

  logic [1:0]  modeNow;
  logic [1:0]  modeNew;
  logic [1:0]  modeChg;

  assign modeNow = {progIf[2], progIf[0]};
  assign modeNew = {cfgWrData[10], cfgWrData[8]};
  assign modeChg = strobe.progIfWr ? (modeNew ^ modeNow) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN)                progIf <= PROG_IF_INIT;
    else if (strobe.progIfWr) progIf <= cfgWrData[15:8];
  end

  // shadow copies of every base register
  for (genvar g = 0; g < NUM_BARS; g++) begin : gShadow
    logic [31:0] merged;
    assign merged = mergeBytes(shadowBar[g], cfgWrData, cfgByteEn);
    always_ff @(posedge clk) begin
      if (!rstN)
        shadowBar[g] <= fixedBase(g);
      else if (strobe.barWr[g] && !strobe.barProbe)
        shadowBar[g] <= merged;
    end
  end

  // live decode bases for the channel blocks
  for (genvar g = 0; g < NUM_CH_BARS; g++) begin : gLive
    localparam int CH = g / 2;
    always_ff @(posedge clk) begin
      if (!rstN)
        liveBar[g] <= fixedBase(g);
      else if (modeChg[CH])
        liveBar[g] <= modeNew[CH] ? shadowBar[g] : fixedBase(g);
      else if (strobe.barWr[g] && !strobe.barProbe && modeNow[CH])
        liveBar[g] <= gShadow[g].merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intLine <= INT_LINE_INIT;
      intPin  <= INT_PIN_INIT;
    end else if (strobe.intrWr) begin
      if (cfgByteEn[0]) intLine <= cfgWrData[7:0];
      if (cfgByteEn[1]) intPin  <= cfgWrData[15:8];
    end
  end

  for (genvar w = 0; w < VEND_WORDS; w++) begin : gVend
    localparam logic [31:0] KEEP = (w == STAT_WORD) ? ~STAT_MASK : 32'hFFFF_FFFF;
    always_ff @(posedge clk) begin
      if (!rstN)
        vendWord[w] <= '0;
      else if (strobe.vendWr && (strobe.vendIdx == VEND_IDX_W'(w)))
        vendWord[w] <= mergeBytes(vendWord[w], cfgWrData, cfgByteEn) & KEEP;
    end
  end

  logic setReq;
  logic clrReq;
  assign setReq = priIrqReq && !irqPrev;
  assign clrReq = strobe.vendWr && (strobe.vendIdx == VEND_IDX_W'(STAT_WORD)) &&
                  cfgByteEn[0] && cfgWrData[STAT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev <= priIrqReq;
      statBit <= 1'b0;
    end else begin
      irqPrev <= priIrqReq;
      if (setReq)      statBit <= 1'b1;
      else if (clrReq) statBit <= 1'b0;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_ID:    cfgRdData = {DEVICE_ID, VENDOR_ID};
      RD_CLASS: cfgRdData = {CLASS_CODE, progIf, REVISION};
      RD_BAR:   cfgRdData = (strobe.barIdx < BAR_IDX_W'(NUM_CH_BARS)) ?
                            liveBar[strobe.barIdx[1:0]] : shadowBar[NUM_BARS-1];
      RD_INTR:  cfgRdData = {16'h0000, intPin, intLine};
      RD_VEND:  cfgRdData = vendWord[strobe.vendIdx] |
                            ((strobe.vendIdx == VEND_IDX_W'(STAT_WORD) && statBit) ?
                             STAT_MASK : 32'h0);
      RD_BM:    cfgRdData = bmCfgRdData;
      default:  cfgRdData = '0;
    endcase
  end

  assign priCmdBase = liveBar[0];
  assign priCtlBase = liveBar[1];
  assign secCmdBase = liveBar[2];
  assign secCtlBase = liveBar[3];
  assign bmBase     = shadowBar[NUM_BARS-1];
  assign bmEnable   = progIf[0];
  assign chNative   = modeNow;
  assign intOut     = statBit;

endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
  import ide_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1AB3,
  parameter logic [15:0] DEVICE_ID     = 16'h0C46,
  parameter logic [7:0]  REVISION      = 8'h07,
  parameter logic [15:0] CLASS_CODE    = 16'h0101,
  parameter logic [7:0]  PROG_IF_INIT  = 8'h80,
  parameter logic [7:0]  INT_LINE_INIT = 8'h0E,
  parameter logic [7:0]  INT_PIN_INIT  = 8'h01
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  input  logic [3:0]  cfgByteEn,
  output logic [31:0] cfgRdData,
  input  logic        priIrqReq,
  output logic        intOut,
  output logic [31:0] priCmdBase,
  output logic [31:0] priCtlBase,
  output logic [31:0] secCmdBase,
  output logic [31:0] secCtlBase,
  output logic [31:0] bmBase,
  output logic        bmEnable,
  output logic [1:0]  chNative,
  output logic [1:0]  bmCfgSel,
  output logic        bmCfgOff,
  output logic        bmCfgWr,
  output logic        bmCfgRd,
  input  logic [31:0] bmCfgRdData
);

  cfgStrobe_t strobe;

  ide_cfg_ctrl uCtrl (
    .cfgWrEn   (cfgWrEn),
    .cfgRdEn   (cfgRdEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgByteEn (cfgByteEn),
    .strobe    (strobe),
    .bmCfgSel  (bmCfgSel),
    .bmCfgOff  (bmCfgOff),
    .bmCfgWr   (bmCfgWr),
    .bmCfgRd   (bmCfgRd)
  );

  ide_cfg_dp #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .REVISION      (REVISION),
    .CLASS_CODE    (CLASS_CODE),
    .PROG_IF_INIT  (PROG_IF_INIT),
    .INT_LINE_INIT (INT_LINE_INIT),
    .INT_PIN_INIT  (INT_PIN_INIT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgWrData   (cfgWrData),
    .cfgByteEn   (cfgByteEn),
    .priIrqReq   (priIrqReq),
    .bmCfgRdData (bmCfgRdData),
    .cfgRdData   (cfgRdData),
    .priCmdBase  (priCmdBase),
    .priCtlBase  (priCtlBase),
    .secCmdBase  (secCmdBase),
    .secCtlBase  (secCtlBase),
    .bmBase      (bmBase),
    .bmEnable    (bmEnable),
    .chNative    (chNative),
    .intOut      (intOut)
  );

endmodule

// File: rtl/ide_cfg_checker.sv
module ide_cfg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic        cfgRdEn,
  input logic [7:0]  cfgAddr,
  input logic [31:0] cfgWrData,
  input logic [3:0]  cfgByteEn,
  input logic        priIrqReq,
  input logic        intOut,
  input logic [31:0] priCmdBase,
  input logic [31:0] priCtlBase,
  input logic [31:0] secCmdBase,
  input logic [31:0] secCtlBase,
  input logic [31:0] bmBase,
  input logic [1:0]  chNative,
  input logic [1:0]  bmCfgSel
);

  logic barAccess;
  logic probeWr;
  logic clearWr;
  logic bmAccess;

  assign barAccess = (cfgAddr[7:2] >= 6'd4) && (cfgAddr[7:2] <= 6'd8);
  assign probeWr   = cfgWrEn && barAccess && (cfgByteEn == 4'hF) &&
                     (cfgWrData == 32'hFFFF_FFFF);
  assign clearWr   = cfgWrEn && (cfgAddr[7:2] == 6'd20) && cfgByteEn[0] && cfgWrData[2];
  assign bmAccess  = (cfgWrEn || cfgRdEn) && (cfgAddr[7:4] == 4'h7);

  p_pri_legacy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !chNative[0] |-> (priCmdBase == 32'h1F0 && priCtlBase == 32'h3F4));

  p_sec_legacy_r3: assert property (@(posedge clk) disable iff (!rstN)
    !chNative[1] |-> (secCmdBase == 32'h170 && secCtlBase == 32'h374));

  p_probe_inert_r5: assert property (@(posedge clk) disable iff (!rstN)
    probeWr |=> ($stable(priCmdBase) && $stable(priCtlBase) && $stable(secCmdBase) &&
                 $stable(secCtlBase) && $stable(bmBase)));

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(priIrqReq) |=> intOut);

  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !$rose(priIrqReq)) |=> !intOut);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && !clearWr) |=> intOut);

  p_alias_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bmCfgSel));

  p_alias_decode_r12: assert property (@(posedge clk) disable iff (!rstN)
    bmAccess |-> (bmCfgSel == (cfgAddr[3] ? 2'b10 : 2'b01)));

endmodule

bind ide_cfg_space ide_cfg_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgRdEn    (cfgRdEn),
  .cfgAddr    (cfgAddr),
  .cfgWrData  (cfgWrData),
  .cfgByteEn  (cfgByteEn),
  .priIrqReq  (priIrqReq),
  .intOut     (intOut),
  .priCmdBase (priCmdBase),
  .priCtlBase (priCtlBase),
  .secCmdBase (secCmdBase),
  .secCtlBase (secCtlBase),
  .bmBase     (bmBase),
  .chNative   (chNative),
  .bmCfgSel   (bmCfgSel)
);

// File: tb/ide_cfg_space_test.sv
module ide_cfg_space_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgRdData;
  logic        priIrqReq = 1'b0;
  logic        intOut;
  logic [31:0] priCmdBase, priCtlBase, secCmdBase, secCtlBase, bmBase;
  logic        bmEnable;
  logic [1:0]  chNative;
  logic [1:0]  bmCfgSel;
  logic        bmCfgOff, bmCfgWr, bmCfgRd;
  logic [31:0] bmCfgRdData = 32'hDEAD_BEEF;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] expShadow [5];
  logic [31:0] expVend [8];
  logic [7:0]  expProg;
  logic        expStat;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_cfg_space uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgByteEn(cfgByteEn),
    .cfgRdData(cfgRdData), .priIrqReq(priIrqReq), .intOut(intOut),
    .priCmdBase(priCmdBase), .priCtlBase(priCtlBase),
    .secCmdBase(secCmdBase), .secCtlBase(secCtlBase),
    .bmBase(bmBase), .bmEnable(bmEnable), .chNative(chNative),
    .bmCfgSel(bmCfgSel), .bmCfgOff(bmCfgOff), .bmCfgWr(bmCfgWr),
    .bmCfgRd(bmCfgRd), .bmCfgRdData(bmCfgRdData)
  );

  function automatic logic [31:0] legacyVal(input int i);
    logic [31:0] t [4] = '{32'h1F0, 32'h3F4, 32'h170, 32'h374};
    return t[i];
  endfunction

  function automatic logic [31:0] byteMix(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expBase(input int i);
    logic nat = (i < 2) ? expProg[0] : expProg[2];
    return nat ? expShadow[i] : legacyVal(i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgByteEn = be; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgRdEn = 1'b1;
    #1 d = cfgRdData;
    cfgRdEn = 1'b0;
  endtask

  task automatic checkBases(input string req);
    chk(req, priCmdBase, expBase(0));
    chk(req, priCtlBase, expBase(1));
    chk(req, secCmdBase, expBase(2));
    chk(req, secCtlBase, expBase(3));
    chk(req, bmBase, expShadow[4]);
    chk({req, " R7"}, {31'd0, bmEnable}, {31'd0, expProg[0]});
    chk(req, {30'd0, chNative}, {30'd0, expProg[2], expProg[0]});
  endtask

  task automatic setProg(input logic [7:0] p);
    doWr(8'h08, {8'hA5, 8'h5A, p, 8'hC3}, 4'hF);
    expProg = p;
  endtask

  initial begin
    logic [31:0] rd;
    expShadow = '{32'h1F0, 32'h3F4, 32'h170, 32'h374, 32'hF00};
    expProg = 8'h80;
    expStat = 1'b0;
    for (int w = 0; w < 8; w++) expVend[w] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    checkBases("R1");
    doRd(8'h3C, rd);
    chk("R1 intr bytes", rd, 32'h0000_010E);
    doRd(8'h08, rd);
    chk("R8 class reset", rd, {16'h0101, 8'h80, 8'h07});
    chk("R11 reset", {31'd0, intOut}, 32'd0);

    // R4 legacy writes go to shadow only; BAR4 live
    for (int i = 0; i < 4; i++) begin
      doWr(8'h10 + 8'(i*4), 32'h0000_C001 + 32'(i*32'h100), 4'hF);
      expShadow[i] = 32'h0000_C001 + 32'(i*32'h100);
      checkBases("R4 legacy write");
    end
    doWr(8'h20, 32'h0000_E001, 4'hF);
    expShadow[4] = 32'h0000_E001;
    checkBases("R4 bar4 write");
    doRd(8'h10, rd);
    chk("R2 legacy read", rd, 32'h1F0);

    // R6 sweep over mode bit combinations, R8 class bytes read-only
    for (int p = 0; p < 16; p++) begin
      setProg({4'h8, 4'(p)});
      checkBases("R6 sweep");
      doRd(8'h08, rd);
      chk("R8 class word", rd, {16'h0101, expProg, 8'h07});
    end

    // R4 native write lands live; R13 partial merge; R5 probe
    setProg(8'h85);
    checkBases("R6 both native");
    doWr(8'h10, 32'h0000_D001, 4'hF);
    expShadow[0] = 32'h0000_D001;
    checkBases("R4 native write");
    doWr(8'h18, 32'h1234_ABCD, 4'b0011);
    expShadow[2] = byteMix(expShadow[2], 32'h1234_ABCD, 4'b0011);
    checkBases("R13 partial low");
    doWr(8'h1C, 32'h5678_9ABC, 4'b1100);
    expShadow[3] = byteMix(expShadow[3], 32'h5678_9ABC, 4'b1100);
    checkBases("R13 partial high");
    doWr(8'h14, 32'hFFFF_FFFF, 4'hF);
    checkBases("R5 probe native");
    doWr(8'h20, 32'hFFFF_FFFF, 4'hF);
    checkBases("R5 probe bar4");
    setProg(8'h80);
    checkBases("R6 back to legacy");
    doWr(8'h14, 32'hFFFF_FFFF, 4'hF);
    doWr(8'h1C, 32'h0000_B001, 4'hF);
    expShadow[3] = 32'h0000_B001;
    checkBases("R3 legacy secondary write");
    setProg(8'h85);
    checkBases("R5 R6 shadow restored");
    setProg(8'h84);
    checkBases("R2 primary only legacy");

    // R9 interrupt routing bytes
    doWr(8'h3C, 32'h1234_5678, 4'b0001);
    doRd(8'h3C, rd);
    chk("R9 line", rd, 32'h0000_0178);
    doWr(8'h3C, 32'h1234_5678, 4'b0010);
    doRd(8'h3C, rd);
    chk("R9 pin", rd, 32'h0000_5678);

    // R10 vendor window sweep
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 2; k++) begin
        logic [3:0]  be = k ? 4'b0101 : 4'hF;
        logic [31:0] d  = (32'h1111_1111 * 32'(w + 1)) ^ (k ? 32'hF0F0_F0F0 : 32'h0);
        doWr(8'h40 + 8'(w*4), d, be);
        expVend[w] = byteMix(expVend[w], d, be) & ((w == 4) ? ~32'h4 : 32'hFFFF_FFFF);
        doRd(8'h40 + 8'(w*4), rd);
        chk("R10 vendor word", rd, expVend[w] | ((w == 4 && expStat) ? 32'h4 : 32'h0));
      end
    end

    // R11 interrupt status
    @(negedge clk);
    priIrqReq = 1'b1;
    @(negedge clk);
    expStat = 1'b1;
    chk("R11 set on edge", {31'd0, intOut}, 32'd1);
    doRd(8'h50, rd);
    chk("R11 status readback", rd, expVend[4] | 32'h4);
    doWr(8'h50, 32'h0000_0004, 4'b0001);
    expVend[4] = byteMix(expVend[4], 32'h4, 4'b0001) & ~32'h4;
    expStat = 1'b0;
    chk("R11 clear", {31'd0, intOut}, 32'd0);
    doRd(8'h50, rd);
    chk("R11 cleared readback", rd, expVend[4]);
    doWr(8'h50, 32'h0000_0000, 4'b1110);
    chk("R11 no clear without byte0", {31'd0, intOut}, 32'd0);
    @(negedge clk);
    priIrqReq = 1'b0;
    @(negedge clk);
    priIrqReq = 1'b1;
    cfgAddr = 8'h50; cfgWrData = 32'h0000_0004; cfgByteEn = 4'b0001; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    expVend[4] = byteMix(expVend[4], 32'h4, 4'b0001) & ~32'h4;
    chk("R11 set wins", {31'd0, intOut}, 32'd1);
    @(negedge clk);
    chk("R11 level no retrigger hold", {31'd0, intOut}, 32'd1);

    // R12 bus-master aliases
    @(negedge clk);
    cfgAddr = 8'h74; cfgWrEn = 1'b1; cfgWrData = 32'h0; cfgByteEn = 4'h0;
    #1;
    chk("R12 primary sel", {30'd0, bmCfgSel}, 32'd1);
    chk("R12 offset", {31'd0, bmCfgOff}, 32'd1);
    chk("R12 write strobe", {31'd0, bmCfgWr}, 32'd1);
    @(negedge clk);
    cfgWrEn = 1'b0;
    for (int a = 8'h68; a < 8'h84; a += 4) begin
      @(negedge clk);
      cfgAddr = 8'(a); cfgRdEn = 1'b1;
      #1;
      if (a >= 8'h70 && a < 8'h80) begin
        chk("R12 alias sel", {30'd0, bmCfgSel}, (a >= 8'h78) ? 32'd2 : 32'd1);
        chk("R12 alias off", {31'd0, bmCfgOff}, 32'((a >> 2) & 1));
        chk("R12 alias data", cfgRdData, 32'hDEAD_BEEF);
        chk("R12 read strobe", {31'd0, bmCfgRd}, 32'd1);
      end else begin
        chk("R12 outside", {30'd0, bmCfgSel}, 32'd0);
        chk("R12 outside data", cfgRdData, 32'd0);
      end
      cfgRdEn = 1'b0;
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule